// File: doc/BRIEF.md
# Selectable-Distance Circular Left Rotator

This block rotates a 28-bit word to the left by one or by two bit positions. Bits leaving the top of the word re-enter at the bottom, so no bit is ever lost. A 4-bit unsigned control value picks the distance through an irregular decode. Four control codes select the short rotation of one place, and the remaining twelve codes select the long rotation of two places.

The block has no clock and no state. The control value is decoded into a single select line. That line steers a 2:1 choice at each output bit, between the wire that carries the bit one place below it and the wire that carries the bit two places below it, both taken modulo the width. The set of short-distance codes is a parameter mask, so a different decode only changes that parameter and leaves the wiring untouched.

Top module: `sel_rotl`

## Requirements
- R1: When `ctl` is 0, 1, 8 or 15, `dout` is `din` rotated left by one place: `dout[0] = din[27]` and `dout[i] = din[i-1]` for i from 1 to 27.
- R2: For every other value of `ctl`, `dout` is `din` rotated left by two places: `dout[0] = din[26]`, `dout[1] = din[27]` and `dout[i] = din[i-2]` for i from 2 to 27.
- R3: With `din` = 28'h9999999 and a short-distance code, `dout` is 28'h3333333.
- R4: With `din` = 28'h9999999 and a long-distance code, `dout` is 28'h6666666.
- R5: The number of set bits in `dout` always equals the number of set bits in `din`.
- R6: `dout` follows any change of `din` or `ctl` combinationally, with no clock and no reset. An all-zero `din` gives an all-zero `dout` for every `ctl`.
- R7: With only bit 27 of `din` set, `dout` is 28'h0000001 for a short-distance code and 28'h0000002 for a long-distance code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 28 | Word to be rotated |
| ctl | input | 4 | Unsigned code that picks the rotation distance |
| dout | output | 28 | Rotated word |

## Verification
The checker's properties assume that `din` and `ctl` are two-state values that have settled when they are evaluated. They are evaluated as combinational checks whenever the ports change, and they assume no other timing. The bench drives both inputs together on the falling edge of its pacing clock and reads `dout` one nanosecond later. It never drives X or Z. It sweeps all sixteen codes against fixed and pseudo-random words, so every short and long decode is exercised.

// File: rtl/rotl_pkg.sv
package rotl_pkg;
    // Default geometry of the rotator
    localparam int ROT_W_DEF = 28;
    localparam int CTL_W_DEF = 4;
    // Bit k set means code k selects the one-place rotation (codes 15, 8, 1, 0)
    localparam logic [15:0] SHORT_SET_DEF = 16'h8103;
endpackage

// File: rtl/rotl_dist_dec.sv
module rotl_dist_dec #(
    parameter int CTL_W = rotl_pkg::CTL_W_DEF,
    parameter logic [(2**CTL_W)-1:0] SHORT_SET = rotl_pkg::SHORT_SET_DEF
) (
    input  logic [CTL_W-1:0] ctl,
    output logic             one_step_d
);
    // Mask lookup: one select line for the whole word
    always_comb begin
        one_step_d = SHORT_SET[ctl];
    end
endmodule

// File: rtl/rotl_wiring.sv
module rotl_wiring #(
    parameter int W = rotl_pkg::ROT_W_DEF
) (
    input  logic [W-1:0] din,
    input  logic         one_step,
    output logic [W-1:0] dout_d
);
    // Each output bit picks between the source one place below and two places below
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int SRC1 = (i + W - 1) % W;
        localparam int SRC2 = (i + W - 2) % W;
        always_comb begin
            dout_d[i] = one_step ? din[SRC1] : din[SRC2];
        end
    end
endmodule

// File: rtl/sel_rotl.sv
module sel_rotl #(
    parameter int W = rotl_pkg::ROT_W_DEF,
    parameter int CTL_W = rotl_pkg::CTL_W_DEF,
    parameter logic [(2**CTL_W)-1:0] SHORT_SET = rotl_pkg::SHORT_SET_DEF
) (
    input  logic [W-1:0]     din,
    input  logic [CTL_W-1:0] ctl,
    output logic [W-1:0]     dout
);
    logic one_step_d;

    rotl_dist_dec #(
        .CTL_W     (CTL_W),
        .SHORT_SET (SHORT_SET)
    ) u_dec (
        .ctl        (ctl),
        .one_step_d (one_step_d)
    );

    rotl_wiring #(
        .W (W)
    ) u_wire (
        .din      (din),
        .one_step (one_step_d),
        .dout_d   (dout)
    );
endmodule

// File: rtl/sel_rotl_chk.sv
module sel_rotl_chk #(
    parameter int W = rotl_pkg::ROT_W_DEF,
    parameter int CTL_W = rotl_pkg::CTL_W_DEF,
    parameter logic [(2**CTL_W)-1:0] SHORT_SET = rotl_pkg::SHORT_SET_DEF
) (
    input logic [W-1:0]     din,
    input logic [CTL_W-1:0] ctl,
    input logic [W-1:0]     dout
);
    logic short_sel;
    logic [W-1:0] msb_only;

    always_comb begin
        short_sel = SHORT_SET[ctl];
        msb_only  = '0;
        msb_only[W-1] = 1'b1;
    end

    always_comb begin
        // R1
        one_place_chk: assert (!short_sel || dout == {din[W-2:0], din[W-1]});
        // R2
        two_place_chk: assert (short_sel || dout == {din[W-3:0], din[W-1:W-2]});
        // R5
        popcount_keep_chk: assert ($countones(dout) == $countones(din));
        // R7
        msb_wrap_chk: assert (din != msb_only || dout == (short_sel ? W'(1) : W'(2)));
        // R6
        zero_keep_chk: assert (din != '0 || dout == '0);
    end

    if (W == 28) begin : g_known
        always_comb begin
            // R3
            known_short_chk: assert (!(din == 28'h9999999 && short_sel) || dout == 28'h3333333);
            // R4
            known_long_chk: assert (!(din == 28'h9999999 && !short_sel) || dout == 28'h6666666);
        end
    end
endmodule

bind sel_rotl sel_rotl_chk #(
    .W         (W),
    .CTL_W     (CTL_W),
    .SHORT_SET (SHORT_SET)
) u_chk (
    .din  (din),
    .ctl  (ctl),
    .dout (dout)
);

// File: tb/tb_sel_rotl.sv
module tb_sel_rotl;
    localparam int W = 28;

    logic clk = 1'b0;
    logic [W-1:0] din;
    logic [3:0]   ctl;
    logic [W-1:0] dout;
    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    sel_rotl dut (
        .din  (din),
        .ctl  (ctl),
        .dout (dout)
    );

    function automatic logic [W-1:0] ref_rot(input logic [W-1:0] v, input int d);
        logic [W-1:0] t = v;
        for (int k = 0; k < d; k++) t = {t[W-2:0], t[W-1]};
        return t;
    endfunction

    function automatic int ref_dist(input logic [3:0] c);
        return (c == 4'd0 || c == 4'd1 || c == 4'd8 || c == 4'd15) ? 1 : 2;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s din=%h ctl=%0d actual=%h expected=%h", req, din, ctl, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] v, input logic [3:0] c);
        @(negedge clk);
        din = v;
        ctl = c;
        #1;
    endtask

    task automatic sweep(input logic [W-1:0] v);
        for (int c = 0; c < 16; c++) begin
            apply(v, 4'(c));
            // R1 / R2 against the reference rotation
            check(ref_dist(4'(c)) == 1 ? "R1" : "R2", dout, ref_rot(v, ref_dist(4'(c))));
            // R5 population count
            check("R5", W'($countones(dout)), W'($countones(v)));
        end
    endtask

    initial begin
        logic [31:0] rnd;
        din = '0;
        ctl = '0;
        // R6: idle state, zero in gives zero out
        #2;
        check("R6", dout, '0);

        sweep(28'h0000000);
        sweep(28'hFFFFFFF);
        sweep(28'h8000000);
        sweep(28'h5555555);
        sweep(28'hAAAAAAA);
        sweep(28'h9999999);
        for (int k = 0; k < 6; k++) begin
            rnd = $urandom();
            sweep(rnd[W-1:0]);
        end

        // R3 / R4 known words
        apply(28'h9999999, 4'd15);
        check("R3", dout, 28'h3333333);
        apply(28'h9999999, 4'd1);
        check("R3", dout, 28'h3333333);
        apply(28'h9999999, 4'd9);
        check("R4", dout, 28'h6666666);
        apply(28'h9999999, 4'd14);
        check("R4", dout, 28'h6666666);

        // R7 top bit wraps around
        apply(28'h8000000, 4'd8);
        check("R7", dout, 28'h0000001);
        apply(28'h8000000, 4'd7);
        check("R7", dout, 28'h0000002);

        // R6 output follows inputs between clock edges with no edge involved
        @(posedge clk);
        #1;
        din = 28'h0000003;
        ctl = 4'd0;
        #1;
        check("R6", dout, 28'h0000006);
        ctl = 4'd2;
        #1;
        check("R6", dout, 28'h000000C);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule